// File: doc/BRIEF.md
# Waiting-Priority Scheduling Buffer

This block holds the pending requests to run a serializing code region on one fast core. A single instance serves one fast core, and all of that core's hardware thread contexts share it. Each slow core owns exactly one slot. A request carries a region identifier, an entry address, a stack address, the origin core and the current count of cycles that threads have spent waiting on that region. Update messages can refresh that waiting count later, matched by region identifier.

When the fast core reports a free context, the buffer picks the held request that is ready to run and has the largest waiting count. Ties go to the lowest slot index. The buffer hands the picked request out on the issue port one cycle later. A ready request that keeps losing builds up age. Once its age reaches a programmable limit, the buffer returns the request to its origin core on the bounce port, which stops one busy region from starving an independent one.

Each slot runs a two-state machine:
- `SLOT_EMPTY` becomes `SLOT_HELD` on ALLOC, when a request names that core.
- `SLOT_HELD` goes back to `SLOT_EMPTY` on ISSUE (the slot was picked) or on BOUNCE (its age expired and it was chosen to return).
- While held, REFRESH (a matching update) and AGE (ready but passed over) keep the slot in `SLOT_HELD`.

Top module: `wps_sched_buf`

## Requirements
- R1: After reset every slot is empty, and `iss_valid` and `bnc_valid` are low.
- R2: When `req_valid` is high, a request naming core c is stored in slot c, provided that slot is empty. The request stays there until it is issued or bounced. The issue and bounce ports return the stored identifier, entry address and stack address unchanged.
- R3: When slot c is already held, a new request for core c is dropped, and the first request stays in the slot unchanged.
- R4: The buffer issues only in a cycle where `ctx_free` is high and at least one held slot is ready. It issues at most one request per cycle. `iss_valid` and the issue fields appear on the clock edge after the cycle in which the request was chosen.
- R5: Among the held slots whose `slot_ready` bit is set, the buffer issues the one with the largest waiting count.
- R6: When waiting counts are equal, the lowest slot index wins.
- R7: An update (`upd_valid`) writes `upd_twc` into every held slot whose identifier equals `upd_bid`.
- R8: A held slot whose ready bit is low is never issued, never bounced, and does not age.
- R9: A held slot ages by one in each cycle it is ready and neither issued nor bounced, and its age saturates at `age_limit`. In a cycle where such a slot is ready, is not issued, and already has age ≥ `age_limit`, the buffer bounces it. At most one bounce happens per cycle, lowest index first, and `bnc_*` is valid on the next edge.
- R10: Issue or bounce frees the slot, and the slot accepts a new request afterwards with its age set to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_free | input | 1 | Fast core has a free thread context |
| age_limit | input | AGE_W | Passed-over cycles allowed before a bounce |
| req_valid | input | 1 | New request present |
| req_core | input | CORE_W | Origin core, which is also the slot index |
| req_bid | input | BID_W | Region identifier |
| req_pc | input | ADDR_W | Region entry address |
| req_sp | input | ADDR_W | Caller stack address |
| req_twc | input | TWC_W | Waiting-cycle count |
| upd_valid | input | 1 | Waiting-count refresh present |
| upd_bid | input | BID_W | Identifier to refresh |
| upd_twc | input | TWC_W | New waiting count |
| slot_ready | input | N_SLOTS | Per-slot ready to run |
| iss_valid | output | 1 | Request handed to the fast core |
| iss_core | output | CORE_W | Origin core of the issued request |
| iss_bid | output | BID_W | Identifier of the issued request |
| iss_pc | output | ADDR_W | Entry address of the issued request |
| iss_sp | output | ADDR_W | Stack address of the issued request |
| bnc_valid | output | 1 | Request returned to its origin |
| bnc_core | output | CORE_W | Core receiving the returned request |
| bnc_bid | output | BID_W | Identifier of the returned request |
| bnc_pc | output | ADDR_W | Entry address of the returned request |
| bnc_sp | output | ADDR_W | Stack address of the returned request |

## Verification
The assertions assume three things about the inputs:
- `age_limit` does not drop below an age a slot has already reached.
- A request never targets a slot in the same cycle that slot is issued or bounced.
- `slot_ready` and `ctx_free` are settled before the sampling edge.

The stimulus respects this. It changes every input just after a rising edge, changes `age_limit` only while the buffer is empty, and places a second request on an occupied slot only when that slot is not ready, so it cannot leave in that cycle.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/sbuf_slot.sv
module sbuf_slot
    import sbuf_pkg::*;
#(
    parameter int BID_W  = 12,
    parameter int ADDR_W = 32,
    parameter int TWC_W  = 16,
    parameter int AGE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [BID_W-1:0]  in_bid,
    input  logic [ADDR_W-1:0] in_pc,
    input  logic [ADDR_W-1:0] in_sp,
    input  logic [TWC_W-1:0]  in_twc,
    input  logic              upd_valid,
    input  logic [BID_W-1:0]  upd_bid,
    input  logic [TWC_W-1:0]  upd_twc,
    input  logic              ready,
    input  logic              grant,
    input  logic              bounce,
    input  logic [AGE_W-1:0]  age_limit,
    output logic              held,
    output logic              eligible,
    output logic              expired,
    output logic [BID_W-1:0]  bid_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [TWC_W-1:0]  twc_o
);
    slot_state_e       state_q, state_d;
    logic [BID_W-1:0]  bid_q;
    logic [ADDR_W-1:0] pc_q, sp_q;
    logic [TWC_W-1:0]  twc_q;
    logic [AGE_W-1:0]  age_q;

    // next-state: ALLOC, ISSUE, BOUNCE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (alloc)           state_d = SLOT_HELD;
            SLOT_HELD:  if (grant || bounce) state_d = SLOT_EMPTY;
            default:                         state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // payload, REFRESH and AGE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bid_q <= '0;
            pc_q  <= '0;
            sp_q  <= '0;
            twc_q <= '0;
            age_q <= '0;
        end else if (state_q == SLOT_EMPTY) begin
            if (alloc) begin
                bid_q <= in_bid;
                pc_q  <= in_pc;
                sp_q  <= in_sp;
                twc_q <= in_twc;
                age_q <= '0;
            end
        end else begin
            if (upd_valid && (bid_q == upd_bid))
                twc_q <= upd_twc;
            if (ready && !grant && !bounce && (age_q < age_limit))
                age_q <= age_q + 1'b1;
        end
    end

    assign held     = (state_q == SLOT_HELD);
    assign eligible = held && ready;
    assign expired  = eligible && (age_q >= age_limit);
    assign bid_o    = bid_q;
    assign pc_o     = pc_q;
    assign sp_o     = sp_q;
    assign twc_o    = twc_q;

    AST_KEEP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (held && alloc && !grant && !bounce) |=> ($stable(bid_q) && $stable(pc_q))); // R3
    AST_BOUNCE_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        bounce |-> (expired && !grant)); // R9
endmodule

// File: rtl/sbuf_pick.sv
module sbuf_pick #(
    parameter int N_SLOTS = 4,
    parameter int TWC_W   = 16,
    parameter int CORE_W  = 2
) (
    input  logic                          enable,
    input  logic [N_SLOTS-1:0]            elig,
    input  logic [N_SLOTS-1:0][TWC_W-1:0] twc,
    output logic [N_SLOTS-1:0]            grant,
    output logic [CORE_W-1:0]             win_idx,
    output logic                          any
);
    logic [TWC_W-1:0] best;
    logic             found;

    // strict greater-than keeps the lower index on ties
    always_comb begin
        best    = '0;
        found   = 1'b0;
        win_idx = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (elig[i] && (!found || (twc[i] > best))) begin
                best    = twc[i];
                found   = 1'b1;
                win_idx = CORE_W'(i);
            end
        end
        any   = enable && found;
        grant = '0;
        if (any) grant[win_idx] = 1'b1;
    end
endmodule

// File: rtl/sbuf_lowest.sv
module sbuf_lowest #(
    parameter int N_SLOTS = 4,
    parameter int CORE_W  = 2
) (
    input  logic [N_SLOTS-1:0] req,
    output logic [N_SLOTS-1:0] sel,
    output logic [CORE_W-1:0]  idx,
    output logic               any
);
    always_comb begin
        sel = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = CORE_W'(i);
                any = 1'b1;
            end
        end
        if (any) sel[idx] = 1'b1;
    end
endmodule

// File: rtl/wps_sched_buf.sv
module wps_sched_buf #(
    parameter int N_SLOTS = 4,
    parameter int BID_W   = 12,
    parameter int ADDR_W  = 32,
    parameter int TWC_W   = 16,
    parameter int AGE_W   = 8,
    localparam int CORE_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctx_free,
    input  logic [AGE_W-1:0]   age_limit,
    input  logic               req_valid,
    input  logic [CORE_W-1:0]  req_core,
    input  logic [BID_W-1:0]   req_bid,
    input  logic [ADDR_W-1:0]  req_pc,
    input  logic [ADDR_W-1:0]  req_sp,
    input  logic [TWC_W-1:0]   req_twc,
    input  logic               upd_valid,
    input  logic [BID_W-1:0]   upd_bid,
    input  logic [TWC_W-1:0]   upd_twc,
    input  logic [N_SLOTS-1:0] slot_ready,
    output logic               iss_valid,
    output logic [CORE_W-1:0]  iss_core,
    output logic [BID_W-1:0]   iss_bid,
    output logic [ADDR_W-1:0]  iss_pc,
    output logic [ADDR_W-1:0]  iss_sp,
    output logic               bnc_valid,
    output logic [CORE_W-1:0]  bnc_core,
    output logic [BID_W-1:0]   bnc_bid,
    output logic [ADDR_W-1:0]  bnc_pc,
    output logic [ADDR_W-1:0]  bnc_sp
);
    logic [N_SLOTS-1:0]            held_v, elig_v, exp_v, grant_v, bnc_sel_v;
    logic [N_SLOTS-1:0][TWC_W-1:0] twc_v;
    logic [BID_W-1:0]              bid_a [N_SLOTS];
    logic [ADDR_W-1:0]             pc_a  [N_SLOTS];
    logic [ADDR_W-1:0]             sp_a  [N_SLOTS];
    logic [CORE_W-1:0]             win_idx, bnc_idx;
    logic                          any_grant, any_bnc;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        sbuf_slot #(
            .BID_W (BID_W),
            .ADDR_W(ADDR_W),
            .TWC_W (TWC_W),
            .AGE_W (AGE_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (req_valid && (req_core == CORE_W'(g))),
            .in_bid   (req_bid),
            .in_pc    (req_pc),
            .in_sp    (req_sp),
            .in_twc   (req_twc),
            .upd_valid(upd_valid),
            .upd_bid  (upd_bid),
            .upd_twc  (upd_twc),
            .ready    (slot_ready[g]),
            .grant    (grant_v[g]),
            .bounce   (bnc_sel_v[g]),
            .age_limit(age_limit),
            .held     (held_v[g]),
            .eligible (elig_v[g]),
            .expired  (exp_v[g]),
            .bid_o    (bid_a[g]),
            .pc_o     (pc_a[g]),
            .sp_o     (sp_a[g]),
            .twc_o    (twc_v[g])
        );
    end

    sbuf_pick #(
        .N_SLOTS(N_SLOTS),
        .TWC_W  (TWC_W),
        .CORE_W (CORE_W)
    ) u_pick (
        .enable (ctx_free),
        .elig   (elig_v),
        .twc    (twc_v),
        .grant  (grant_v),
        .win_idx(win_idx),
        .any    (any_grant)
    );

    sbuf_lowest #(
        .N_SLOTS(N_SLOTS),
        .CORE_W (CORE_W)
    ) u_bounce (
        .req(exp_v & ~grant_v),
        .sel(bnc_sel_v),
        .idx(bnc_idx),
        .any(any_bnc)
    );

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_core  <= '0;
            iss_bid   <= '0;
            iss_pc    <= '0;
            iss_sp    <= '0;
            bnc_valid <= 1'b0;
            bnc_core  <= '0;
            bnc_bid   <= '0;
            bnc_pc    <= '0;
            bnc_sp    <= '0;
        end else begin
            iss_valid <= any_grant;
            if (any_grant) begin
                iss_core <= win_idx;
                iss_bid  <= bid_a[win_idx];
                iss_pc   <= pc_a[win_idx];
                iss_sp   <= sp_a[win_idx];
            end
            bnc_valid <= any_bnc;
            if (any_bnc) begin
                bnc_core <= bnc_idx;
                bnc_bid  <= bid_a[bnc_idx];
                bnc_pc   <= pc_a[bnc_idx];
                bnc_sp   <= sp_a[bnc_idx];
            end
        end
    end

    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_v)); // R4
    AST_ISSUE_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> $past(ctx_free)); // R4
    AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_v & ~(held_v & slot_ready)) == '0)); // R8
    AST_SPLIT_CORES: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && bnc_valid) |-> (iss_core != bnc_core)); // R9
endmodule

// File: tb/wps_sched_buf_tb.sv
module wps_sched_buf_tb;
    localparam int N = 4, BW = 12, AW = 32, TW = 16, GW = 8, CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctx_free = 1'b0;
    logic [GW-1:0] age_limit = 8'd200;
    logic          req_valid = 1'b0;
    logic [CW-1:0] req_core = '0;
    logic [BW-1:0] req_bid = '0;
    logic [AW-1:0] req_pc = '0, req_sp = '0;
    logic [TW-1:0] req_twc = '0;
    logic          upd_valid = 1'b0;
    logic [BW-1:0] upd_bid = '0;
    logic [TW-1:0] upd_twc = '0;
    logic [N-1:0]  slot_ready = '0;
    logic          iss_valid, bnc_valid;
    logic [CW-1:0] iss_core, bnc_core;
    logic [BW-1:0] iss_bid, bnc_bid;
    logic [AW-1:0] iss_pc, iss_sp, bnc_pc, bnc_sp;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;

    wps_sched_buf #(.N_SLOTS(N), .BID_W(BW), .ADDR_W(AW), .TWC_W(TW), .AGE_W(GW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctx_free(ctx_free), .age_limit(age_limit),
        .req_valid(req_valid), .req_core(req_core), .req_bid(req_bid),
        .req_pc(req_pc), .req_sp(req_sp), .req_twc(req_twc),
        .upd_valid(upd_valid), .upd_bid(upd_bid), .upd_twc(upd_twc),
        .slot_ready(slot_ready),
        .iss_valid(iss_valid), .iss_core(iss_core), .iss_bid(iss_bid),
        .iss_pc(iss_pc), .iss_sp(iss_sp),
        .bnc_valid(bnc_valid), .bnc_core(bnc_core), .bnc_bid(bnc_bid),
        .bnc_pc(bnc_pc), .bnc_sp(bnc_sp)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put_req(input int core, input int bid, input int twc);
        req_valid = 1'b1;
        req_core  = CW'(core);
        req_bid   = BW'(bid);
        req_pc    = AW'(32'h1000 + bid);
        req_sp    = AW'(32'h8000 + bid);
        req_twc   = TW'(twc);
        tick();
        req_valid = 1'b0;
    endtask

    task automatic expect_issue(input string tag, input int core, input int bid);
        chk({tag, " iss_valid"}, 64'(iss_valid), 64'd1);
        chk({tag, " iss_core"}, 64'(iss_core), 64'(core));
        chk({tag, " iss_bid"}, 64'(iss_bid), 64'(bid));
    endtask

    task automatic t_reset();
        chk("R1 iss_valid", 64'(iss_valid), 64'd0);
        chk("R1 bnc_valid", 64'(bnc_valid), 64'd0);
        ctx_free = 1'b1; slot_ready = '1;
        tick();
        chk("R1 empty after reset", 64'(iss_valid), 64'd0);
        ctx_free = 1'b0; slot_ready = '0;
    endtask

    task automatic t_order();
        put_req(0, 'h100, 5);
        put_req(1, 'h101, 20);
        put_req(2, 'h102, 20);
        put_req(3, 'h103, 9);
        slot_ready = '1; ctx_free = 1'b1;
        tick(); expect_issue("R5 R6 first", 1, 'h101);
        tick(); expect_issue("R6 tie second", 2, 'h102);
        tick(); expect_issue("R5 third", 3, 'h103);
        tick(); expect_issue("R5 last", 0, 'h100);
        tick(); chk("R10 drained", 64'(iss_valid), 64'd0);
        ctx_free = 1'b0; slot_ready = '0;
    endtask

    task automatic t_dup();
        put_req(2, 'h2AA, 10);
        put_req(2, 'h2BB, 50);
        slot_ready = 4'b0100; ctx_free = 1'b1;
        tick(); expect_issue("R3 first kept", 2, 'h2AA);
        chk("R2 pc", 64'(iss_pc), 64'(32'h1000 + 'h2AA));
        chk("R2 sp", 64'(iss_sp), 64'(32'h8000 + 'h2AA));
        tick(); chk("R3 second dropped", 64'(iss_valid), 64'd0);
        put_req(2, 'h2CC, 1);
        chk("R4 latency", 64'(iss_valid), 64'd0);
        tick(); expect_issue("R10 reuse", 2, 'h2CC);
        tick(); chk("R10 empty", 64'(iss_valid), 64'd0);
        ctx_free = 1'b0; slot_ready = '0;
    endtask

    task automatic t_gate();
        put_req(1, 'h311, 7);
        slot_ready = 4'b0010;
        for (int k = 0; k < 3; k++) begin
            tick(); chk("R4 no free ctx", 64'(iss_valid), 64'd0);
        end
        ctx_free = 1'b1; slot_ready = '0;
        for (int k = 0; k < 3; k++) begin
            tick(); chk("R8 not ready", 64'(iss_valid), 64'd0);
        end
        slot_ready = 4'b0010;
        tick(); expect_issue("R4 issue", 1, 'h311);
        ctx_free = 1'b0; slot_ready = '0;
        tick();
    endtask

    task automatic t_update();
        put_req(0, 'h411, 5);
        put_req(1, 'h422, 10);
        put_req(3, 'h411, 1);
        upd_valid = 1'b1; upd_bid = BW'('h411); upd_twc = TW'(100);
        tick();
        upd_valid = 1'b0;
        slot_ready = '1; ctx_free = 1'b1;
        tick(); expect_issue("R7 refreshed", 0, 'h411);
        tick(); expect_issue("R7 both matches", 3, 'h411);
        tick(); expect_issue("R7 unmatched", 1, 'h422);
        tick(); chk("R7 drained", 64'(iss_valid), 64'd0);
        ctx_free = 1'b0; slot_ready = '0;
    endtask

    task automatic t_bounce();
        age_limit = 8'd3;
        put_req(3, 'h533, 4);
        for (int k = 0; k < 5; k++) begin
            tick(); chk("R8 no aging", 64'(bnc_valid), 64'd0);
        end
        slot_ready = 4'b1000;
        for (int k = 0; k < 3; k++) begin
            tick(); chk("R9 before limit", 64'(bnc_valid), 64'd0);
        end
        tick();
        chk("R9 bounce valid", 64'(bnc_valid), 64'd1);
        chk("R9 bounce core", 64'(bnc_core), 64'd3);
        chk("R9 bounce bid", 64'(bnc_bid), 64'h533);
        chk("R2 bounce pc", 64'(bnc_pc), 64'(32'h1000 + 'h533));
        tick(); chk("R9 single pulse", 64'(bnc_valid), 64'd0);
        ctx_free = 1'b1;
        tick(); chk("R10 freed by bounce", 64'(iss_valid), 64'd0);
        ctx_free = 1'b0; slot_ready = '0;
    endtask

    task automatic t_two_bounce();
        age_limit = 8'd1;
        put_req(0, 'h600, 3);
        put_req(2, 'h602, 3);
        slot_ready = 4'b0101;
        tick(); chk("R9 aging", 64'(bnc_valid), 64'd0);
        tick();
        chk("R9 lowest first", 64'(bnc_valid), 64'd1);
        chk("R9 lowest core", 64'(bnc_core), 64'd0);
        tick();
        chk("R9 next bounce", 64'(bnc_valid), 64'd1);
        chk("R9 next core", 64'(bnc_core), 64'd2);
        tick(); chk("R9 done", 64'(bnc_valid), 64'd0);
        slot_ready = '0; age_limit = 8'd200;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_order();
        t_dup();
        t_gate();
        t_update();
        t_bounce();
        t_two_bounce();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule